// File: doc/BRIEF.md
# Bit Error Inserter

This block sits in a serial test-pattern path, one bit per enabled clock. It passes each pattern bit through a single output register. It can flip chosen bits to inject errors, and it can invert the whole stream. The inverted stream is meant for a later stage that adds framing overhead or stuff bits, so inversion here always comes before that stage.

Errors come from two kinds of source:
- A periodic source fires once every 10^n enabled bits, where n is set by a rate code.
- A single-shot source takes one request at a time, either from a register strobe or from an external manual pin. A select input picks which of the two is active.

Each injected error flips exactly one data bit. A one-cycle pulse on a separate output marks that bit.

Top module: `bitflip_inserter`

## Requirements
- R1: After reset, `bitOut` and `errPulse` are 0. On each clock edge where `bitEn` is 1, `bitOut` takes `bitIn ^ invertEn ^ flip`, where `flip` is 1 when an error is applied to that bit. When `bitEn` is 0, `bitOut` holds its value and `errPulse` is 0 on the next cycle.
- R2: When `invertEn` is 1, every enabled bit leaves inverted. This includes bits that carry an injected error, which then come out equal to `bitIn`.
- R3: For `rateCode` = n with 1 ≤ n ≤ 7, the 10^n-th enabled bit counted from the restart point is flipped, and every 10^n-th bit after it. The restart point is reset or the last rate change.
- R4: `rateCode` = 0 turns periodic insertion off, so no periodic error is inserted.
- R5: Any change of `rateCode` restarts the periodic count. The enabled bits seen under the old code do not count toward the next periodic error.
- R6: With `srcSel` = 0, a cycle with `regErrStrobe` = 1 raises one single-error request. The request flips the next enabled bit after that cycle and no other bit.
- R7: With `srcSel` = 1, `manualErrIn` passes through a two-flop synchronizer followed by an edge detector. Each rising edge raises one request. A level held high raises only one.
- R8: The source not selected by `srcSel` raises no request.
- R9: A pending single request and a periodic error that fall on the same bit produce one flip and one pulse, and the request is consumed.
- R10: `errPulse` is 1 for exactly one cycle, in the same cycle as the flipped bit appears on `bitOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitIn | input | 1 | Pattern bit |
| bitEn | input | 1 | Qualifies `bitIn` for this cycle |
| rateCode | input | 3 | Periodic error exponent n (0 = off) |
| srcSel | input | 1 | Single-error source: 0 = register strobe, 1 = manual pin |
| regErrStrobe | input | 1 | Register-driven single-error request |
| manualErrIn | input | 1 | Asynchronous manual error input |
| invertEn | input | 1 | Invert the whole stream |
| bitOut | output | 1 | Modified pattern bit |
| errPulse | output | 1 | Marks the bit that carries an injected error |

## Verification
The assertions assume that `bitIn`, `bitEn`, `invertEn` and `rateCode` are synchronous to `clk` and are sampled only at the edges where the design reads them. Only `manualErrIn` may change at any time.

The bench drives every input on the falling edge. It changes `rateCode` and `srcSel` only in cycles where `bitEn` is 0, and each rate change is followed by an idle cycle. This keeps the restart of the periodic count separate from the counting of a data bit.

Manual edges are held for several idle cycles before the next data bit. This gives the synchronizer time to pass the edge before that bit arrives.

// File: rtl/bitflip_pkg.sv
package bitflip_pkg;

  // Per-bit error decisions handed from control to datapath.
  typedef struct packed {
    logic periodicHit;  // periodic error lands on the current enabled bit
    logic singleHit;    // pending single request consumed on the current enabled bit
  } ctrlHits_t;

  // 10^exp - 1, the reload point of the periodic bit counter.
  function automatic int decadeLimit(input int exp);
    int v;
    v = 1;
    for (int k = 0; k < exp; k++) v = v * 10;
    return v - 1;
  endfunction

endpackage

// File: rtl/bitflip_ctrl.sv
module bitflip_ctrl
  import bitflip_pkg::*;
#(
  parameter int RATE_W      = 3,
  parameter int MAX_EXP     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              srcSel,
  input  logic              regErrStrobe,
  input  logic              manualErrIn,
  output ctrlHits_t         hits,
  output logic              pendingQ,
  output logic              trigNow
);

  localparam int CNT_W   = $clog2(decadeLimit(MAX_EXP) + 1);
  localparam int N_CODES = 2 ** RATE_W;

  // Reload limit for each rate code. Codes above MAX_EXP clamp to the slowest rate.
  logic [CNT_W-1:0] limTab [N_CODES];
  for (genvar g = 0; g < N_CODES; g++) begin : g_lim
    localparam int EXP_G = (g > MAX_EXP) ? MAX_EXP : g;
    assign limTab[g] = CNT_W'(decadeLimit(EXP_G));
  end

  // Synchronizer chain for the manual pin.
  logic [SYNC_STAGES-1:0] syncQ;
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= manualErrIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[s] <= 1'b0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  end

  logic manPrevQ;
  logic manRise;
  always_ff @(posedge clk) begin
    if (!rstN) manPrevQ <= 1'b0;
    else       manPrevQ <= syncQ[SYNC_STAGES-1];
  end
  assign manRise = syncQ[SYNC_STAGES-1] & ~manPrevQ;

  // Single-error request. Only the selected source is honoured.
  always_comb begin
    trigNow = srcSel ? manRise : regErrStrobe;
  end

  logic pendingD;
  always_comb begin
    pendingD = pendingQ;
    if (bitEn && pendingQ) pendingD = 1'b0;  // consumed by this bit
    if (trigNow)           pendingD = 1'b1;  // a new request waits for the next bit
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= pendingD;
  end

  // Periodic decade counter.
  logic [RATE_W-1:0] rateQ;
  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  limSel;
  logic              rateChanged;
  logic              rateOff;
  logic              periodicNow;

  always_comb begin
    limSel      = limTab[rateCode];
    rateChanged = (rateCode != rateQ);
    rateOff     = (rateCode == '0);
    periodicNow = bitEn && !rateChanged && !rateOff && (cntQ == limSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ <= '0;
      cntQ  <= '0;
    end else begin
      rateQ <= rateCode;
      if (rateChanged || rateOff) cntQ <= '0;
      else if (bitEn)             cntQ <= periodicNow ? '0 : cntQ + 1'b1;
    end
  end

  always_comb begin
    hits.periodicHit = periodicNow;
    hits.singleHit   = bitEn & pendingQ;
  end

endmodule

// File: rtl/bitflip_datapath.sv
module bitflip_datapath
  import bitflip_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      bitIn,
  input  logic      bitEn,
  input  logic      invertEn,
  input  ctrlHits_t hits,
  output logic      bitOut,
  output logic      errPulse
);

  // A collision of both sources still flips the bit only once.
  logic flipNow;
  always_comb begin
    flipNow = hits.periodicHit | hits.singleHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitOut   <= 1'b0;
      errPulse <= 1'b0;
    end else if (bitEn) begin
      bitOut   <= bitIn ^ invertEn ^ flipNow;
      errPulse <= flipNow;
    end else begin
      errPulse <= 1'b0;
    end
  end

endmodule

// File: rtl/bitflip_inserter.sv
module bitflip_inserter
  import bitflip_pkg::*;
#(
  parameter int RATE_W      = 3,
  parameter int MAX_EXP     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitIn,
  input  logic              bitEn,
  input  logic [RATE_W-1:0] rateCode,
  input  logic              srcSel,
  input  logic              regErrStrobe,
  input  logic              manualErrIn,
  input  logic              invertEn,
  output logic              bitOut,
  output logic              errPulse
);

  ctrlHits_t hits;
  logic      pendingQ;
  logic      trigNow;

  bitflip_ctrl #(
    .RATE_W(RATE_W), .MAX_EXP(MAX_EXP), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .rateCode(rateCode),
    .srcSel(srcSel), .regErrStrobe(regErrStrobe), .manualErrIn(manualErrIn),
    .hits(hits), .pendingQ(pendingQ), .trigNow(trigNow)
  );

  bitflip_datapath u_dp (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitEn(bitEn),
    .invertEn(invertEn), .hits(hits), .bitOut(bitOut), .errPulse(errPulse)
  );

endmodule

// File: rtl/bitflip_inserter_chk.sv
module bitflip_inserter_chk #(
  parameter int RATE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              bitIn,
  input logic              bitEn,
  input logic              invertEn,
  input logic [RATE_W-1:0] rateCode,
  input logic              bitOut,
  input logic              errPulse,
  input logic              pendingQ,
  input logic              trigNow
);

  AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> !errPulse);  // R10

  AST_IDLE_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(bitOut));  // R1

  AST_OUT_MAPPING: assert property (@(posedge clk) disable iff (!rstN)
    bitEn |=> (bitOut == ($past(bitIn) ^ $past(invertEn) ^ errPulse)));  // R2

  AST_OFF_NO_PERIODIC: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && rateCode == '0 && !pendingQ) |=> !errPulse);  // R4

  AST_REQ_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    (bitEn && pendingQ && !trigNow) |=> (!pendingQ && errPulse));  // R9

  AST_REQ_RAISED: assert property (@(posedge clk) disable iff (!rstN)
    trigNow |=> pendingQ);  // R6

endmodule

bind bitflip_inserter bitflip_inserter_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitEn(bitEn), .invertEn(invertEn),
  .rateCode(rateCode), .bitOut(bitOut), .errPulse(errPulse),
  .pendingQ(pendingQ), .trigNow(trigNow)
);

// File: tb/bitflip_inserter_tb.sv
`timescale 1ns/1ps
module bitflip_inserter_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bitIn = 1'b0;
  logic       bitEn = 1'b0;
  logic [2:0] rateCode = 3'd0;
  logic       srcSel = 1'b0;
  logic       regErrStrobe = 1'b0;
  logic       manualErrIn = 1'b0;
  logic       invertEn = 1'b0;
  logic       bitOut;
  logic       errPulse;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  bitflip_inserter u_dut (
    .clk(clk), .rstN(rstN), .bitIn(bitIn), .bitEn(bitEn), .rateCode(rateCode),
    .srcSel(srcSel), .regErrStrobe(regErrStrobe), .manualErrIn(manualErrIn),
    .invertEn(invertEn), .bitOut(bitOut), .errPulse(errPulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Send one enabled bit and compare output and pulse one edge later.
  task automatic sendBit(input logic b, input logic expErr, input string req);
    @(negedge clk);
    bitIn = b;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    check({req, " data"}, bitOut, b ^ invertEn ^ expErr);
    check({req, " pulse"}, errPulse, expErr);
  endtask

  // Pass through code 0 so that any target code counts as a rate change.
  task automatic setRate(input logic [2:0] n);
    @(negedge clk); rateCode = 3'd0;
    @(negedge clk); rateCode = n;
    @(negedge clk);
  endtask

  task automatic pulseReg();
    @(negedge clk); regErrStrobe = 1'b1;
    @(negedge clk); regErrStrobe = 1'b0;
  endtask

  function automatic logic patBit(input int i);
    return logic'(i[0] ^ i[2] ^ i[3]);
  endfunction

  task automatic tReset();
    @(negedge clk);
    check("R1 reset bitOut", bitOut, 1'b0);
    check("R1 reset errPulse", errPulse, 1'b0);
  endtask

  task automatic tPassThrough();
    setRate(3'd0);
    invertEn = 1'b0;
    for (int i = 0; i < 40; i++) sendBit(patBit(i), 1'b0, "R1 R4 passthrough");
    // An idle cycle keeps the output and gives no pulse.
    idle(2);
    check("R1 hold after idle", bitOut, patBit(39));
    check("R10 no pulse when idle", errPulse, 1'b0);
  endtask

  task automatic tInvert();
    setRate(3'd0);
    invertEn = 1'b1;
    for (int i = 0; i < 20; i++) sendBit(patBit(i), 1'b0, "R2 inversion");
    invertEn = 1'b0;
  endtask

  task automatic tPeriodic(input logic [2:0] n, input int nBits);
    int period;
    period = 1;
    for (int k = 0; k < n; k++) period = period * 10;
    setRate(n);
    for (int i = 1; i <= nBits; i++)
      sendBit(patBit(i), (i % period) == 0, "R3 periodic");
    setRate(3'd0);
  endtask

  task automatic tPeriodicInverted();
    setRate(3'd1);
    invertEn = 1'b1;
    for (int i = 1; i <= 10; i++) sendBit(1'b1, i == 10, "R2 R3 error under inversion");
    invertEn = 1'b0;
    setRate(3'd0);
  endtask

  task automatic tRateRestart();
    setRate(3'd1);
    for (int i = 1; i <= 7; i++) sendBit(patBit(i), 1'b0, "R5 before change");
    @(negedge clk); rateCode = 3'd2;
    @(negedge clk); rateCode = 3'd1;
    @(negedge clk);
    for (int i = 1; i <= 10; i++) sendBit(patBit(i), i == 10, "R5 restart count");
    setRate(3'd0);
  endtask

  task automatic tSingleReg();
    setRate(3'd0);
    srcSel = 1'b0;
    pulseReg();
    idle(3);
    for (int i = 0; i < 5; i++) sendBit(patBit(i), i == 0, "R6 register single");
    // Strobe held for several cycles still raises one request.
    @(negedge clk); regErrStrobe = 1'b1;
    idle(3);
    regErrStrobe = 1'b0;
    for (int i = 0; i < 4; i++) sendBit(patBit(i), i == 0, "R6 held strobe");
  endtask

  task automatic tSingleManual();
    setRate(3'd0);
    srcSel = 1'b1;
    @(negedge clk); manualErrIn = 1'b1;
    idle(10);
    for (int i = 0; i < 5; i++) sendBit(patBit(i), i == 0, "R7 manual edge");
    for (int i = 0; i < 3; i++) sendBit(patBit(i), 1'b0, "R7 level held");
    @(negedge clk); manualErrIn = 1'b0;
    idle(4);
    manualErrIn = 1'b1;
    idle(5);
    for (int i = 0; i < 3; i++) sendBit(patBit(i), i == 0, "R7 second edge");
    manualErrIn = 1'b0;
    idle(4);
  endtask

  task automatic tIgnoredSource();
    setRate(3'd0);
    srcSel = 1'b1;
    pulseReg();
    idle(2);
    for (int i = 0; i < 3; i++) sendBit(patBit(i), 1'b0, "R8 strobe ignored");
    srcSel = 1'b0;
    @(negedge clk); manualErrIn = 1'b1;
    idle(6);
    for (int i = 0; i < 3; i++) sendBit(patBit(i), 1'b0, "R8 pin ignored");
    manualErrIn = 1'b0;
    idle(4);
  endtask

  task automatic tCollision();
    srcSel = 1'b0;
    setRate(3'd1);
    for (int i = 1; i <= 9; i++) sendBit(patBit(i), 1'b0, "R9 lead-in");
    pulseReg();
    sendBit(1'b0, 1'b1, "R9 single flip on collision");
    for (int i = 11; i <= 20; i++) sendBit(patBit(i), i == 20, "R9 request consumed");
    setRate(3'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    tReset();
    tPassThrough();
    tInvert();
    tPeriodic(3'd1, 30);
    tPeriodic(3'd2, 200);
    tPeriodic(3'd3, 2000);
    tPeriodicInverted();
    tRateRestart();
    tSingleReg();
    tSingleManual();
    tIgnoredSource();
    tCollision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule